// File: doc/BRIEF.md
# Burst-Clock Stereo Serial Audio Transmitter

This block transmits stereo audio samples as an I2S slave. An external master supplies the bit clock and the word select. The block never drives either of them. It only drives the serial data line. The master's bit clock does not run continuously: it comes in bursts of pulses, with idle gaps between them. A slot is normally 24 pulses long, and that length stays the same when only 16 sample bits are sent. For this reason the block runs on its own fast system clock, which must be at least eight times the bit clock rate. It passes both incoming clocks through two-flop synchronizers and acts on the edges it detects. It never uses them as clocks.

Samples arrive on a valid/ready stream, one left/right pair per transfer. A single holding register sits between the stream and the serializer. `s_ready` is high while that register is empty. A pair is accepted on any clock cycle where `s_valid` and `s_ready` are both high. `s_ready` then stays low until the next frame start takes the pair, so a source stalls for at most one frame. A frame starts at each falling edge of word select. When a frame starts with no pair held, the block sends a silent frame and raises a sticky underflow flag.

The frame uses standard I2S alignment: the MSB of each slot follows the word-select transition by one bit-clock pulse. Every word-select edge resets the position counter, so the frame realigns even after lost or extra bit-clock edges.

Top module: `i2s_burst_tx`

## Requirements
- R1: After reset, `sd_out` is 0, `underflow` is 0 and `s_ready` is 1.
- R2: `sd_out` changes only after a detected falling edge of the bit clock. Word select low selects the left slot and word select high selects the right slot. On pulse k of a slot, counting the pulse that carries the word-select change as k=0, the block drives slot bit 24-k for k=1..23, where bit 23 is the MSB. Pulse k=0 of the next slot carries the slot's last bit.
- R3: When `wide_sel`=1, the slot carries bits 31..8 of the 32-bit input word, MSB first. Input bits 7..0 never appear on `sd_out`.
- R4: When `wide_sel`=0, the slot carries input bits 31..16, MSB first, and then 8 zero bits.
- R5: `wide_sel` is sampled only at a falling edge of word select. A change of `wide_sel` during a frame does not affect the right slot of that frame.
- R6: `s_ready` is high exactly when no pair is held. After a transfer it stays low, and further `s_valid` activity is ignored until the next frame start takes the held pair.
- R7: If no pair is held at a frame start, both slots of that frame send zeros and `underflow` goes to 1. `underflow` then stays at 1 until reset.
- R8: If a slot receives more than 24 pulses, every pulse from the 25th onward drives 0. This includes the pulse carrying the next word-select edge.
- R9: If a slot receives fewer than 24 pulses, the pulse carrying the next word-select edge drives the next unsent bit, and the following slot starts with its MSB.
- R10: While the bit clock and word select are idle between bursts, for any length of time, `sd_out` holds its value, and the next burst continues without loss of alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; at least 8x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Bit clock from the master, asynchronous |
| ws_in | input | 1 | Word select from the master, asynchronous (0 = left) |
| wide_sel | input | 1 | Sample width select: 1 = 24-bit, 0 = 16-bit |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding register empty, pair can be accepted |
| s_left | input | 32 | Left sample, MSB-justified |
| s_right | input | 32 | Right sample, MSB-justified |
| sd_out | output | 1 | Registered serial data |
| underflow | output | 1 | Sticky: a frame started with no sample pair |

## Verification
A change on `bclk_in` or `ws_in` passes through the two synchronizer flops and is detected by comparing with the previous synchronized value. The registered `sd_out` therefore updates on the third system clock edge after the input change. The bench acts as the master and holds each bit-clock half period for 10 system cycles. It samples `sd_out` at the end of each low half, just before raising the bit clock, which is well after that three-cycle delay. `s_ready` falls on the clock edge after a transfer. `underflow` rises one cycle after the word-select fall is detected. The bench checks both several cycles later, never at the edge itself.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
endpackage

// File: rtl/i2s_edge_sync.sv
module i2s_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;
  logic              level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~last;
  assign fall  = ~level & last;
endmodule

// File: rtl/i2s_pair_buffer.sv
module i2s_pair_buffer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_left,
  input  logic [DW-1:0] in_right,
  input  logic          take,
  output logic          have,
  output logic [DW-1:0] out_left,
  output logic [DW-1:0] out_right
);
  logic accept;

  assign in_ready = ~have;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      have <= 1'b0;
    else if (accept) have <= 1'b1;
    else if (take)   have <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_left  <= in_left;
      out_right <= in_right;
    end
  end
endmodule

// File: rtl/i2s_slot_serializer.sv
module i2s_slot_serializer
  import i2s_tx_pkg::*;
#(
  parameter int IN_W     = 32,
  parameter int SLOT_W   = 24,
  parameter int NARROW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bclk_fall,
  input  logic            ws_fall,
  input  logic            ws_rise,
  input  logic            wide,
  input  logic            have,
  input  logic [IN_W-1:0] raw_left,
  input  logic [IN_W-1:0] raw_right,
  output logic            sd,
  output logic            ovr
);
  localparam int CW = $clog2(SLOT_W);
  localparam logic [CW-1:0] LAST_MID = CW'(SLOT_W - 1);

  logic [SLOT_W-1:0] act;
  logic [SLOT_W-1:0] right_w;
  logic [CW-1:0]     cnt;
  chan_e             ch;

  function automatic logic [SLOT_W-1:0] fmt(input logic [IN_W-1:0] x, input logic w);
    if (w) return x[IN_W-1 -: SLOT_W];
    return {x[IN_W-1 -: NARROW_W], {(SLOT_W-NARROW_W){1'b0}}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd      <= 1'b0;
      ovr     <= 1'b0;
      act     <= '0;
      right_w <= '0;
      cnt     <= '0;
      ch      <= CH_LEFT;
    end else if (ws_fall) begin
      sd      <= ovr ? 1'b0 : act[SLOT_W-1];
      act     <= have ? fmt(raw_left, wide) : '0;
      right_w <= have ? fmt(raw_right, wide) : '0;
      cnt     <= '0;
      ovr     <= 1'b0;
      ch      <= CH_LEFT;
    end else if (ws_rise) begin
      sd  <= ovr ? 1'b0 : act[SLOT_W-1];
      act <= right_w;
      cnt <= '0;
      ovr <= 1'b0;
      ch  <= CH_RIGHT;
    end else if (bclk_fall) begin
      if (cnt < LAST_MID) begin
        sd  <= act[SLOT_W-1];
        act <= act << 1;
        cnt <= cnt + 1'b1;
      end else begin
        sd  <= 1'b0;
        ovr <= 1'b1;
      end
    end
  end

  logic unused_ch;
  assign unused_ch = ch;
endmodule

// File: rtl/i2s_burst_tx.sv
module i2s_burst_tx #(
  parameter int IN_W        = 32,
  parameter int SLOT_W      = 24,
  parameter int NARROW_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bclk_in,
  input  logic            ws_in,
  input  logic            wide_sel,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [IN_W-1:0] s_left,
  input  logic [IN_W-1:0] s_right,
  output logic            sd_out,
  output logic            underflow
);
  logic bclk_fall, bclk_rise_unused;
  logic ws_fall, ws_rise;
  logic have, ovr;
  logic [IN_W-1:0] held_left, held_right;

  i2s_edge_sync #(.STAGES(SYNC_STAGES)) u_bclk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(bclk_in),
    .rise(bclk_rise_unused), .fall(bclk_fall)
  );

  i2s_edge_sync #(.STAGES(SYNC_STAGES)) u_ws_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ws_in),
    .rise(ws_rise), .fall(ws_fall)
  );

  i2s_pair_buffer #(.DW(IN_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_valid), .in_ready(s_ready),
    .in_left(s_left), .in_right(s_right),
    .take(ws_fall), .have(have),
    .out_left(held_left), .out_right(held_right)
  );

  i2s_slot_serializer #(.IN_W(IN_W), .SLOT_W(SLOT_W), .NARROW_W(NARROW_W)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .bclk_fall(bclk_fall), .ws_fall(ws_fall), .ws_rise(ws_rise),
    .wide(wide_sel), .have(have),
    .raw_left(held_left), .raw_right(held_right),
    .sd(sd_out), .ovr(ovr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 underflow <= 1'b0;
    else if (ws_fall && !have)  underflow <= 1'b1;
  end

  logic unused_rise;
  assign unused_rise = bclk_rise_unused;
endmodule

// File: rtl/i2s_burst_tx_chk.sv
module i2s_burst_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk_fall,
  input logic ws_fall,
  input logic ws_rise,
  input logic ovr,
  input logic s_valid,
  input logic s_ready,
  input logic underflow,
  input logic sd_out
);
  // R10: data stays put when no edge was detected
  a_r10_sd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(bclk_fall || ws_fall || ws_rise) |=> $stable(sd_out));

  // R6: a transfer closes the stream until the frame start
  a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R7: frame start with nothing held raises the flag
  a_r7_underflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_fall && s_ready) |=> underflow);

  // R7: flag is sticky
  a_r7_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R8: after overrun the line stays low
  a_r8_overrun_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && (bclk_fall || ws_fall || ws_rise)) |=> !sd_out);
endmodule

bind i2s_burst_tx i2s_burst_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_fall(bclk_fall), .ws_fall(ws_fall),
  .ws_rise(ws_rise), .ovr(ovr), .s_valid(s_valid), .s_ready(s_ready),
  .underflow(underflow), .sd_out(sd_out)
);

// File: tb/tb_i2s_burst_tx.sv
module tb_i2s_burst_tx;
  localparam int HB = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b1, ws = 1'b1, wide = 1'b1, s_valid = 1'b0;
  logic [31:0] s_left = '0, s_right = '0;
  logic s_ready, sd, underflow;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [23:0] pw;
  int pn;
  bit pvalid = 1'b0;
  string ptag;
  logic [63:0] pgot;

  i2s_burst_tx dut (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .ws_in(ws), .wide_sel(wide),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .sd_out(sd), .underflow(underflow)
  );

  always #5 clk = ~clk;

  function automatic logic [23:0] fmt(logic [31:0] x, bit w);
    return w ? x[31:8] : {x[31:16], 8'h00};
  endfunction

  // expected pulse bits of one slot; bit 0 is the edge pulse of the next slot
  function automatic logic [63:0] expvec(logic [23:0] w, int n);
    logic [63:0] e = '0;
    for (int k = 1; k < n; k++) e[k] = (k <= 23) ? w[24-k] : 1'b0;
    e[0] = (n > 24) ? 1'b0 : w[24-n];
    return e;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic gap(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic pulse(bit first, bit wsv, output logic b);
    @(negedge clk);
    bclk = 1'b0;
    if (first) ws = wsv;
    repeat (HB) @(negedge clk);
    b = sd;
    bclk = 1'b1;
    repeat (HB) @(negedge clk);
  endtask

  task automatic slot(bit wsv, int n, logic [23:0] w, string tag);
    logic b;
    for (int k = 0; k < n; k++) begin
      pulse(k == 0, wsv, b);
      if (k == 0) begin
        if (pvalid) begin
          pgot[0] = b;
          check(ptag, pgot, expvec(pw, pn));
        end
        pgot = '0;
      end else begin
        pgot[k] = b;
      end
    end
    pw = w; pn = n; ptag = tag; pvalid = 1'b1;
  endtask

  task automatic frame(int nl, int nr, logic [23:0] wl, logic [23:0] wr, string tag);
    gap($urandom_range(40, 3));
    slot(1'b0, nl, wl, tag);
    gap($urandom_range(40, 3));
    slot(1'b1, nr, wr, tag);
  endtask

  task automatic push(logic [31:0] l, logic [31:0] r);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_left = l; s_right = r;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] l, r;
    bit w;
    logic s0;
    logic [63:0] moved;
    void'($urandom(32'd7));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {61'b0, sd, underflow, s_ready}, 64'h1);

    // random pairs and widths
    for (int i = 0; i < 6; i++) begin
      l = $urandom; r = $urandom; w = $urandom_range(1, 0);
      wide = w;
      push(l, r);
      frame(24, 24, fmt(l, w), fmt(r, w), w ? "R3" : "R4");
    end
    check("R7", {63'b0, underflow}, 64'h0);

    // directed MSB placement and discarded low byte
    wide = 1'b1;
    push(32'h800000FF, 32'h000001FF);
    frame(24, 24, 24'h800000, 24'h000001, "R2");
    wide = 1'b0;
    push(32'hA5A5FFFF, 32'h0001FFFF);
    frame(24, 24, 24'hA5A500, 24'h000100, "R4");

    // back-pressure: held pair survives further valid activity
    wide = 1'b1;
    push(32'h12345678, 32'h9ABCDEF0);
    gap(2);
    check("R6", {63'b0, s_ready}, 64'h0);
    s_valid = 1'b1; s_left = 32'hFFFFFFFF; s_right = 32'hFFFFFFFF;
    gap(5);
    check("R6", {63'b0, s_ready}, 64'h0);
    s_valid = 1'b0;
    frame(24, 24, 24'h123456, 24'h9ABCDE, "R6");
    gap(3);
    check("R6", {63'b0, s_ready}, 64'h1);

    // width change mid-frame ignored
    wide = 1'b1;
    l = 32'hC3C3C3C3; r = 32'h5A5A5A5A;
    push(l, r);
    gap(10);
    slot(1'b0, 24, fmt(l, 1'b1), "R5");
    wide = 1'b0;
    gap(10);
    slot(1'b1, 24, fmt(r, 1'b1), "R5");
    wide = 1'b1;

    // underflow: silent frame, sticky flag
    frame(24, 24, 24'h0, 24'h0, "R7");
    check("R7", {63'b0, underflow}, 64'h1);
    l = $urandom; r = $urandom;
    push(l, r);
    frame(24, 24, fmt(l, 1'b1), fmt(r, 1'b1), "R7");
    check("R7", {63'b0, underflow}, 64'h1);

    // overrun in the left slot
    l = 32'hFFFFFFFF; r = $urandom;
    push(l, r);
    frame(27, 24, fmt(l, 1'b1), fmt(r, 1'b1), "R8");

    // short slot, then realignment
    l = $urandom; r = $urandom;
    push(l, r);
    frame(20, 24, fmt(l, 1'b1), fmt(r, 1'b1), "R9");

    // long idle gap
    s0 = sd;
    moved = '0;
    for (int j = 0; j < 10; j++) begin
      gap(50);
      if (sd !== s0) moved = 64'h1;
    end
    check("R10", moved, 64'h0);
    l = $urandom; r = $urandom;
    push(l, r);
    frame(24, 24, fmt(l, 1'b1), fmt(r, 1'b1), "R10");

    // flush: closes the last right slot
    push(32'h0, 32'h0);
    frame(24, 24, 24'h0, 24'h0, "R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule